// File: doc/BRIEF.md
# Hilbert FIR Envelope Power Unit

This block turns a stream of real, band-limited signed samples into a stream of envelope power values. It forms an analytic signal: the quadrature path comes from an odd-length FIR Hilbert transformer with fixed coefficients, and the in-phase path is the same sample stream delayed by a whole number of samples so that it lines up with the filter's centre. Each output is the in-phase value squared plus the quadrature value squared, kept at full precision.

The filter has N = 4M-1 taps, where M is the number of nonzero coefficient magnitudes. The centre tap and every tap at an even distance from the centre are zero, and the taps are antisymmetric. Each nonzero pair therefore needs one multiplier, applied to the difference of the two samples it weights. The M coefficient magnitudes are loaded through a plain write port and hold their value during operation.

Both data edges are valid/ready streams. A sample moves on a clock edge where `s_valid` and `s_ready` are both high. A power value moves on an edge where `m_valid` and `m_ready` are both high. When the output register is full and `m_ready` is low, the whole pipeline stalls and `s_ready` goes low. No sample is dropped and no output changes while it waits.

Top module: `hilbert_env_power`

## Requirements
- R1: Every accepted sample produces exactly one output power value, and outputs leave in acceptance order. After reset the sample history holds zeros.
- R2: With x[t] the sample accepted t samples before the newest one (x[0] is the newest) and K = 2M-1, the quadrature value is Q = sum over j = 0..M-1 of c[j]*(x[K-(2j+1)] - x[K+(2j+1)]). The centre tap and taps at an even distance from the centre contribute nothing.
- R3: The in-phase value is I = x[K] * 2^(CW-1). This is an integer delay of K samples, scaled to the coefficients' Q1.(CW-1) fraction.
- R4: The output is I*I + Q*Q as an unsigned value 2*QW+1 bits wide, where QW = IW+1+CW+clog2(M). There is no truncation or saturation, even at the most negative input and coefficient values.
- R5: With `m_ready` held high, `m_valid` for a sample goes high on the third rising edge after the edge that accepts it.
- R6: A write with `coef_we` high stores `coef_wdata` (signed) as c[`coef_sel`] on that edge. All coefficients reset to zero. Writes are made while no sample is in flight.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_power` holds its value.
- R8: `s_ready` is low exactly when `m_valid` is high and `m_ready` is low. A stall freezes every pipeline stage.
- R9: Straight after reset, `m_valid` is low and `s_ready` is high.
- R10: For a sine at a quarter of the sample rate with amplitude A, using coefficients whose alternating sum c0-c1+c2-c3 equals 2^(CW-2), the power settles to A*A*2^(2CW-2) once the history is full, and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | IW | Signed input sample |
| m_valid | output | 1 | Output power valid |
| m_ready | input | 1 | Consumer accepts the power value |
| m_power | output | 2*QW+1 | Unsigned envelope power I*I+Q*Q |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | max(1,clog2(M)) | Index of the coefficient to write |
| coef_wdata | input | CW | Signed coefficient value |

## Verification
A single impulse walks through the history. It separates the odd-distance taps, which carry their own coefficient, from the centre tap, which feeds only the in-phase path, and from the even-distance taps, which must give zero power. A quarter-rate sine with matched coefficients shows whether the two paths keep unit gain and quadrature alignment, because any skew between them breaks the constant power. Extreme inputs and coefficients expose any lost bit in the products or squares. A long random stream with random output back-pressure shows whether stalls drop, repeat or reorder values.

// File: rtl/hfe_pkg.sv
`timescale 1ns/1ps
package hfe_pkg;
  // Number of taps for M nonzero coefficient magnitudes.
  function automatic int hfe_taps(input int m);
    return 4 * m - 1;
  endfunction

  // Distance from the first tap to the centre tap.
  function automatic int hfe_half(input int m);
    return 2 * m - 1;
  endfunction

  // Width of the quadrature sum at full precision.
  function automatic int hfe_acc_w(input int iw, input int cw, input int m);
    return iw + 1 + cw + $clog2(m);
  endfunction
endpackage

// File: rtl/hfe_coef_bank.sv
`timescale 1ns/1ps
module hfe_coef_bank #(
  parameter int M  = 4,
  parameter int CW = 16,
  localparam int SW = (M > 1) ? $clog2(M) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SW-1:0]        sel,
  input  logic [CW-1:0]        wdata,
  output logic signed [CW-1:0] coef_o [M]
);
  for (genvar g = 0; g < M; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coef_o[g] <= '0;
      end else if (we && sel == SW'(g)) begin
        coef_o[g] <= $signed(wdata);
      end
    end
  end

  // R6: a write lands in the selected slot
  p_coef_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(sel) < M) |=> coef_o[$past(sel)] == $signed($past(wdata)));
endmodule

// File: rtl/hfe_tap_line.sv
`timescale 1ns/1ps
module hfe_tap_line #(
  parameter int IW = 14,
  parameter int M  = 4,
  localparam int N  = hfe_pkg::hfe_taps(M),
  localparam int K  = hfe_pkg::hfe_half(M),
  localparam int DW = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 v1_o,
  output logic signed [DW-1:0] diff_o [M],
  output logic signed [IW-1:0] centre_o
);
  logic signed [IW-1:0] hist_q [N-1];
  logic signed [IW-1:0] win    [N];
  logic                 accept;

  assign accept = in_valid && en;

  always_comb begin
    win[0] = in_data;
    for (int i = 1; i < N; i++) win[i] = hist_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N - 1; i++) hist_q[i] <= '0;
    end else if (accept) begin
      hist_q[0] <= in_data;
      for (int i = 1; i < N - 1; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_o     <= 1'b0;
      centre_o <= '0;
    end else if (en) begin
      v1_o <= in_valid;
      if (in_valid) centre_o <= win[K];
    end
  end

  // One subtractor per antisymmetric pair at odd distance 2j+1.
  for (genvar j = 0; j < M; j++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        diff_o[j] <= '0;
      end else if (accept) begin
        diff_o[j] <= DW'(win[K-(2*j+1)]) - DW'(win[K+(2*j+1)]);
      end
    end
  end

  p_accept_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> v1_o);

  p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(v1_o) && $stable(centre_o)));
endmodule

// File: rtl/hfe_mac.sv
`timescale 1ns/1ps
module hfe_mac #(
  parameter int IW = 14,
  parameter int CW = 16,
  parameter int M  = 4,
  localparam int DW = IW + 1,
  localparam int PW = DW + CW,
  localparam int QW = hfe_pkg::hfe_acc_w(IW, CW, M)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v1_i,
  input  logic signed [DW-1:0] diff_i [M],
  input  logic signed [IW-1:0] centre_i,
  input  logic signed [CW-1:0] coef_i [M],
  output logic                 v3_o,
  output logic signed [QW-1:0] i_o,
  output logic signed [QW-1:0] q_o
);
  logic signed [PW-1:0] prod_q [M];
  logic signed [IW-1:0] centre2_q;
  logic                 v2_q;
  logic signed [QW-1:0] acc;

  for (genvar j = 0; j < M; j++) begin : g_mul
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prod_q[j] <= '0;
      end else if (en && v1_i) begin
        prod_q[j] <= PW'(diff_i[j]) * PW'(coef_i[j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2_q      <= 1'b0;
      centre2_q <= '0;
    end else if (en) begin
      v2_q <= v1_i;
      if (v1_i) centre2_q <= centre_i;
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < M; j++) acc = acc + QW'(prod_q[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3_o <= 1'b0;
      i_o  <= '0;
      q_o  <= '0;
    end else if (en) begin
      v3_o <= v2_q;
      if (v2_q) begin
        q_o <= acc;
        i_o <= QW'(centre2_q) <<< (CW - 1);
      end
    end
  end
endmodule

// File: rtl/hfe_power.sv
`timescale 1ns/1ps
module hfe_power #(
  parameter int QW = 33,
  localparam int SQW = 2 * QW,
  localparam int OW  = SQW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v3_i,
  input  logic signed [QW-1:0] i_i,
  input  logic signed [QW-1:0] q_i,
  output logic                 m_valid,
  output logic [OW-1:0]        m_power
);
  logic signed [SQW-1:0] sq_i;
  logic signed [SQW-1:0] sq_q;

  assign sq_i = SQW'(i_i) * SQW'(i_i);
  assign sq_q = SQW'(q_i) * SQW'(q_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_power <= '0;
    end else if (en) begin
      m_valid <= v3_i;
      if (v3_i) m_power <= OW'($unsigned(sq_i)) + OW'($unsigned(sq_q));
    end
  end

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !en) |=> (m_valid && $stable(m_power)));

  p_last_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v3_i) |=> m_valid);

  p_nonzero_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v3_i && (i_i != '0 || q_i != '0)) |=> (m_power != '0));
endmodule

// File: rtl/hilbert_env_power.sv
`timescale 1ns/1ps
module hilbert_env_power #(
  parameter int IW = 14,
  parameter int CW = 16,
  parameter int M  = 4,
  localparam int SW = (M > 1) ? $clog2(M) : 1,
  localparam int DW = IW + 1,
  localparam int QW = hfe_pkg::hfe_acc_w(IW, CW, M),
  localparam int OW = 2 * QW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [IW-1:0] s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [OW-1:0]        m_power,
  input  logic                 coef_we,
  input  logic [SW-1:0]        coef_sel,
  input  logic [CW-1:0]        coef_wdata
);
  logic                 en;
  logic signed [CW-1:0] coef [M];
  logic                 v1;
  logic signed [DW-1:0] diff [M];
  logic signed [IW-1:0] centre;
  logic                 v3;
  logic signed [QW-1:0] ival;
  logic signed [QW-1:0] qval;

  // Global advance: the pipeline moves when the output slot is free or drains.
  assign en      = !m_valid || m_ready;
  assign s_ready = en;

  hfe_coef_bank #(.M(M), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .sel(coef_sel),
    .wdata(coef_wdata), .coef_o(coef)
  );

  hfe_tap_line #(.IW(IW), .M(M)) u_taps (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(s_valid), .in_data(s_data),
    .v1_o(v1), .diff_o(diff), .centre_o(centre)
  );

  hfe_mac #(.IW(IW), .CW(CW), .M(M)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .v1_i(v1), .diff_i(diff),
    .centre_i(centre), .coef_i(coef), .v3_o(v3), .i_o(ival), .q_o(qval)
  );

  hfe_power #(.QW(QW)) u_pow (
    .clk(clk), .rst_n(rst_n), .en(en), .v3_i(v3), .i_i(ival), .q_i(qval),
    .m_valid(m_valid), .m_power(m_power)
  );
endmodule

// File: tb/tb_hilbert_env_power.sv
`timescale 1ns/1ps
module tb_hilbert_env_power;
  localparam int IW = 14;
  localparam int CW = 16;
  localparam int M  = 4;
  localparam int N  = 4 * M - 1;
  localparam int K  = 2 * M - 1;
  localparam int QW = IW + 1 + CW + 2;
  localparam int OW = 2 * QW + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 s_valid = 1'b0;
  logic                 s_ready;
  logic signed [IW-1:0] s_data = '0;
  logic                 m_valid;
  logic                 m_ready = 1'b1;
  logic [OW-1:0]        m_power;
  logic                 coef_we = 1'b0;
  logic [1:0]           coef_sel = '0;
  logic [CW-1:0]        coef_wdata = '0;

  hilbert_env_power dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_power(m_power),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata)
  );

  always #2.5 clk = ~clk;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;
  int hist[$];
  int cf[M];
  logic [OW-1:0] expq[$];
  logic [OW-1:0] outs[$];
  int n_acc = 0;
  int n_out = 0;
  bit hold_pend = 1'b0;
  logic [OW-1:0] held;
  bit rnd_ready = 1'b0;
  int lcg = 7;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference from R2/R3/R4: full-precision I*I+Q*Q over the sample history.
  function automatic logic [127:0] ref_power();
    logic signed [127:0] iv, qv, t;
    iv = 128'(signed'(hist[K])) * (128'sd1 <<< (CW - 1));
    qv = '0;
    for (int j = 0; j < M; j++) begin
      t  = 128'(signed'(hist[K-(2*j+1)] - hist[K+(2*j+1)]));
      qv = qv + t * 128'(signed'(cf[j]));
    end
    return 128'(iv * iv + qv * qv);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) chk(m_valid && m_power == held, "R7 held output", 128'(m_power), 128'(held));
      if (m_valid && !m_ready) chk(!s_ready, "R8 ready low under stall", 128'(s_ready), 128'd0);
      if (m_valid && m_ready) begin
        n_out++;
        outs.push_back(m_power);
        if (expq.size() == 0) chk(1'b0, "R1 unexpected output", 128'(m_power), 128'd0);
        else begin
          logic [OW-1:0] e;
          e = expq.pop_front();
          chk(m_power == e, "R2/R3/R4 power", 128'(m_power), 128'(e));
        end
      end
      hold_pend = m_valid && !m_ready;
      held      = m_power;
      if (coef_we) cf[coef_sel] = int'($signed(coef_wdata));
      if (s_valid && s_ready) begin
        n_acc++;
        hist.push_front(int'(s_data));
        void'(hist.pop_back());
        expq.push_back(OW'(ref_power()));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_ready) begin
      lcg = lcg * 1103515245 + 12345;
      m_ready = lcg[16];
    end else m_ready = 1'b1;
  end

  task automatic send(input int v);
    bit acc;
    s_valid = 1'b1;
    s_data  = v[IW-1:0];
    forever begin
      @(negedge clk);
      acc = s_ready;
      @(posedge clk);
      #1;
      if (acc) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic wr_coef(input int sel, input int val);
    coef_we    = 1'b1;
    coef_sel   = sel[1:0];
    coef_wdata = val[CW-1:0];
    @(posedge clk);
    #1;
    coef_we = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || m_valid) && n < 2000) begin
      @(posedge clk);
      #1;
      n++;
    end
    chk(expq.size() == 0, "R1 drain", 128'(expq.size()), 128'd0);
  endtask

  task automatic flush();
    for (int i = 0; i < N; i++) send(0);
    drain();
    outs.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++;
    miss++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    logic [127:0] e;
    int bad;
    for (int i = 0; i < N; i++) hist.push_back(0);
    for (int j = 0; j < M; j++) cf[j] = 0;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R9 s_ready after reset", 128'(s_ready), 128'd1);
    chk(m_valid == 1'b0, "R9 m_valid after reset", 128'(m_valid), 128'd0);
    @(posedge clk);
    #1;

    // R6: load coefficients with alternating sum 2^(CW-2)
    wr_coef(0, 19661);
    wr_coef(1, 4915);
    wr_coef(2, 2294);
    wr_coef(3, 656);

    // R5: latency with m_ready high
    s_valid = 1'b1;
    s_data  = 14'sd5000;
    @(posedge clk);
    #1;
    s_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(m_valid == 1'b0, "R5 not yet valid after two edges", 128'(m_valid), 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk(m_valid == 1'b1, "R5 valid on third edge", 128'(m_valid), 128'd1);
    @(posedge clk);
    #1;
    drain();

    // R2/R3: impulse walk
    flush();
    send(1000);
    for (int i = 0; i < N + 2; i++) send(0);
    drain();
    e = 128'(32768000) * 128'(32768000);
    chk(outs[K] == OW'(e), "R3 centre tap in-phase only", 128'(outs[K]), e);
    e = 128'(19661000) * 128'(19661000);
    chk(outs[K-1] == OW'(e), "R2 distance one tap", 128'(outs[K-1]), e);
    e = 128'(4915000) * 128'(4915000);
    chk(outs[K+3] == OW'(e), "R2 distance three tap", 128'(outs[K+3]), e);
    chk(outs[K+2] == '0, "R2 even distance tap silent", 128'(outs[K+2]), 128'd0);

    // R10: quarter-rate sine gives constant power after fill
    flush();
    for (int i = 0; i < 80; i++) send((i % 4 == 1) ? 8191 : ((i % 4 == 3) ? -8191 : 0));
    drain();
    e = 128'(8191) * 128'(8191) * (128'd1 << 30);
    bad = -1;
    for (int i = N - 1; i < outs.size(); i++) if (outs[i] != OW'(e) && bad < 0) bad = i;
    chk(bad < 0, "R10 steady sine power", (bad < 0) ? e : 128'(outs[bad]), e);

    // R4: extreme inputs and coefficients
    for (int j = 0; j < M; j++) wr_coef(j, -32768);
    flush();
    for (int i = 0; i < 8; i++) send(8191);
    for (int i = 0; i < 7; i++) send(-8192);
    drain();
    e = 128'(8191 * 32768) * 128'(8191 * 32768) + 128'(64'd2147352576) * 128'(64'd2147352576);
    chk(outs[outs.size()-1] == OW'(e), "R4 full precision extreme", 128'(outs[outs.size()-1]), e);

    // R1/R7/R8: random stream under random back-pressure
    wr_coef(0, 12000);
    wr_coef(1, -3000);
    wr_coef(2, 777);
    wr_coef(3, -20000);
    rnd_ready = 1'b1;
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 1103515245 + 12345;
      send((lcg >>> 8) % 8192);
    end
    rnd_ready = 1'b0;
    drain();
    chk(n_acc == n_out, "R1 one output per sample", 128'(n_out), 128'(n_acc));
    finish_run();
  end
endmodule